// File: doc/BRIEF.md
# Protected Memory-to-Memory Processor Core

This block is a small multicycle processor that works directly on a 256-cell byte memory and has no general registers. Every instruction is four bytes in a row: an operation byte, two source cell addresses and a destination cell address. Operands can be fetched directly or through a pointer cell. The core keeps a program counter, an exception-return counter and a one-bit privilege flag. Value 0 of the flag is system mode and value 1 is user mode.

In user mode, hardware guards the low region of memory, which is cells below 100. It checks the instruction address when an instruction is fetched, the privilege cell when an instruction is decoded, and every operand and destination address, including an address reached through a pointer. A guarded access, a service call, a privilege violation and a timer interrupt each send the core to its own fixed entry address. The core then records the interrupted address and drops to system mode. A return instruction reverses this in one step. The memory port is synchronous: read data appears one cycle after the address. When the core accepts a timer interrupt it pulses an acknowledge line, so the timer can clear its request.

Top module: `m2m_core`

## Requirements
- R1: While and after synchronous reset, the program counter is 0, the core is in system mode, and `mem_we` and `irq_ack` are low.
- R2: The operation code is bits [3:0] of the first instruction byte. Code 1 adds, 2 subtracts, 3 multiplies and 4 divides the first source by the second. The result is kept modulo 256 and written to the destination cell, and the program counter then advances by 4.
- R3: A divide by a zero second source writes 0 to the destination and raises no exception.
- R4: Bit 7 of the operation byte makes the first source indirect, and bit 6 makes the second source indirect. An indirect source cell holds the address of the real operand.
- R5: Code 5 branches to the destination byte when the first source value is zero, and otherwise advances by 4. Code 6 writes the first source minus 1 to the destination. Code 7 jumps to the destination byte.
- R6: Codes 0 and 10 to 15 change nothing and advance the program counter by 4.
- R7: In user mode, a fetch from an address below 100 sets the saved counter to that address, the program counter to 60 and the mode to system.
- R8: In user mode, a source, pointer-target or destination address below 100 vectors to 60 with the instruction address saved, and nothing is written to memory.
- R9: In user mode, an instruction that writes cell 255 (the privilege cell), or a return instruction, vectors to 64 with the instruction address saved.
- R10: Code 8 (service call) saves the address of the next instruction, vectors to 68, enters system mode and presents the first source byte on `trap_num`.
- R11: Code 9 in system mode loads the program counter from the saved counter and sets user mode in the same step.
- R12: When `irq` is high as a fetch begins, the core saves the program counter, vectors to 72, enters system mode and raises `irq_ack` for one cycle. This takes precedence over a fetch violation at the same address.
- R13: In system mode, writing cell 255 sets the mode from bit 0 of the result, and memory cell 255 is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory cell address |
| mem_re | output | 1 | Memory read request; data is returned next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| irq | input | 1 | Timer interrupt request line |
| irq_ack | output | 1 | One-cycle pulse telling the timer to clear its request |
| pc_o | output | 8 | Program counter |
| epc_o | output | 8 | Saved (exception-return) counter |
| user_mode | output | 1 | Privilege flag, 1 = user |
| trap_num | output | 8 | Service number of the latest service call |

## Verification
The timer interrupt check and the user-mode fetch guard both act at the start of a fetch, so they can apply in the same cycle. The bench provokes this by having a user program jump to address 40. It waits until the program counter shows 40, and then raises `irq` before the next edge. The outcome is judged at the ports: the core must land on 72 rather than 60, the saved counter must hold 40, and exactly one acknowledge pulse must appear.

// File: rtl/m2m_pkg.sv
package m2m_pkg;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_MUL  = 4'd3;
  localparam logic [3:0] OP_DIV  = 4'd4;
  localparam logic [3:0] OP_BZ   = 4'd5;
  localparam logic [3:0] OP_DEC  = 4'd6;
  localparam logic [3:0] OP_JMP  = 4'd7;
  localparam logic [3:0] OP_TRAP = 4'd8;
  localparam logic [3:0] OP_RTE  = 4'd9;

  typedef enum logic [2:0] {
    ST_FETCH, ST_LOAD, ST_DECODE, ST_OPADDR, ST_OPLATCH, ST_EXEC
  } core_st_t;
endpackage

// File: rtl/m2m_alu.sv
module m2m_alu #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  import m2m_pkg::*;
  logic [2*W-1:0] prod;
  assign prod = a * b;

  always_comb begin
    case (op)
      OP_ADD:  res = a + b;
      OP_SUB:  res = a - b;
      OP_MUL:  res = prod[W-1:0];
      OP_DIV:  res = (b == '0) ? '0 : a / b;
      OP_DEC:  res = a - W'(1);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/m2m_guard.sv
module m2m_guard #(
  parameter int AW    = 8,
  parameter int LIMIT = 100
) (
  input  logic          en,
  input  logic          user,
  input  logic [AW-1:0] addr,
  output logic          viol
);
  assign viol = en && user && (addr < AW'(LIMIT));
endmodule

// File: rtl/m2m_core.sv
module m2m_core #(
  parameter int AW        = 8,
  parameter int LIMIT     = 100,
  parameter int V_MEM     = 60,
  parameter int V_MODE    = 64,
  parameter int V_TRAP    = 68,
  parameter int V_IRQ     = 72,
  parameter int MODE_CELL = 255,
  parameter int RESET_PC  = 0
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          irq,
  output logic          irq_ack,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] epc_o,
  output logic          user_mode,
  output logic [AW-1:0] trap_num
);
  import m2m_pkg::*;
  localparam logic [AW-1:0] STEP    = AW'(4);
  localparam logic [AW-1:0] MCELL   = AW'(MODE_CELL);

  core_st_t      st;
  logic [2:0]    cnt;
  logic [1:0]    step;
  logic [AW-1:0] pc, epc, ir_op, ir_a, ir_b, ir_d, ea, eb, va, vb;
  logic          user;

  logic [3:0]    op;
  logic          ind_a, ind_b, is_arith, writes, viol, chk_en;
  logic [AW-1:0] chk_addr, cur_addr, alu_res;

  assign op       = ir_op[3:0];
  assign ind_a    = ir_op[7];
  assign ind_b    = ir_op[6];
  assign is_arith = (op >= OP_ADD) && (op <= OP_DIV);
  assign writes   = is_arith || (op == OP_DEC);
  assign cur_addr = step[1] ? eb : ea;

  always_comb begin
    chk_addr = pc;
    chk_en   = 1'b0;
    case (st)
      ST_FETCH:  begin chk_addr = pc;       chk_en = 1'b1;   end
      ST_OPADDR: begin chk_addr = cur_addr; chk_en = 1'b1;   end
      ST_EXEC:   begin chk_addr = ir_d;     chk_en = writes; end
      default:   ;
    endcase
  end

  m2m_guard #(.AW(AW), .LIMIT(LIMIT)) u_guard (
    .en(chk_en), .user(user), .addr(chk_addr), .viol(viol)
  );

  m2m_alu #(.W(AW)) u_alu (
    .op(op), .a(va), .b(vb), .res(alu_res)
  );

  always_comb begin
    mem_addr = pc;
    mem_re   = 1'b0;
    mem_we   = 1'b0;
    case (st)
      ST_FETCH:  begin mem_addr = pc; mem_re = !irq && !viol; end
      ST_LOAD:   begin mem_addr = pc + AW'(cnt); mem_re = (cnt < 3'd4); end
      ST_OPADDR: begin mem_addr = cur_addr; mem_re = !viol; end
      ST_EXEC:   begin
        mem_addr = ir_d;
        mem_we   = writes && !viol && (ir_d != MCELL);
      end
      default: ;
    endcase
  end
  assign mem_wdata = alu_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_FETCH; cnt <= '0; step <= '0;
      pc <= AW'(RESET_PC); epc <= '0; user <= 1'b0;
      ir_op <= '0; ir_a <= '0; ir_b <= '0; ir_d <= '0;
      ea <= '0; eb <= '0; va <= '0; vb <= '0;
      trap_num <= '0; irq_ack <= 1'b0;
    end else begin
      irq_ack <= 1'b0;
      case (st)
        ST_FETCH: begin
          if (irq) begin
            epc <= pc; pc <= AW'(V_IRQ); user <= 1'b0; irq_ack <= 1'b1;
          end else if (viol) begin
            epc <= pc; pc <= AW'(V_MEM); user <= 1'b0;
          end else begin
            cnt <= 3'd1; st <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          case (cnt)
            3'd1:    ir_op <= mem_rdata;
            3'd2:    ir_a  <= mem_rdata;
            3'd3:    ir_b  <= mem_rdata;
            default: ir_d  <= mem_rdata;
          endcase
          cnt <= cnt + 3'd1;
          if (cnt == 3'd4) st <= ST_DECODE;
        end
        ST_DECODE: begin
          st <= ST_FETCH;
          case (op)
            OP_TRAP: begin
              epc <= pc + STEP; pc <= AW'(V_TRAP); user <= 1'b0; trap_num <= ir_a;
            end
            OP_RTE: begin
              if (user) begin
                epc <= pc; pc <= AW'(V_MODE); user <= 1'b0;
              end else begin
                pc <= epc; user <= 1'b1;
              end
            end
            OP_JMP: pc <= ir_d;
            OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_DEC, OP_BZ: begin
              if (writes && user && ir_d == MCELL) begin
                epc <= pc; pc <= AW'(V_MODE); user <= 1'b0;
              end else begin
                ea <= ir_a; eb <= ir_b;
                step <= ind_a ? 2'd0 : 2'd1;
                st <= ST_OPADDR;
              end
            end
            default: pc <= pc + STEP;
          endcase
        end
        ST_OPADDR: begin
          if (viol) begin
            epc <= pc; pc <= AW'(V_MEM); user <= 1'b0; st <= ST_FETCH;
          end else begin
            st <= ST_OPLATCH;
          end
        end
        ST_OPLATCH: begin
          st <= ST_OPADDR;
          case (step)
            2'd0: begin ea <= mem_rdata; step <= 2'd1; end
            2'd1: begin
              va <= mem_rdata;
              if (is_arith) step <= ind_b ? 2'd2 : 2'd3;
              else          st   <= ST_EXEC;
            end
            2'd2: begin eb <= mem_rdata; step <= 2'd3; end
            default: begin vb <= mem_rdata; st <= ST_EXEC; end
          endcase
        end
        ST_EXEC: begin
          st <= ST_FETCH;
          if (op == OP_BZ) begin
            pc <= (va == '0) ? ir_d : pc + STEP;
          end else if (viol) begin
            epc <= pc; pc <= AW'(V_MEM); user <= 1'b0;
          end else begin
            if (ir_d == MCELL) user <= alu_res[0];
            pc <= pc + STEP;
          end
        end
        default: st <= ST_FETCH;
      endcase
    end
  end

  assign pc_o      = pc;
  assign epc_o     = epc;
  assign user_mode = user;
endmodule

// File: rtl/m2m_core_chk.sv
module m2m_core_chk #(
  parameter int LIMIT  = 100,
  parameter int V_MEM  = 60,
  parameter int V_MODE = 64,
  parameter int V_TRAP = 68,
  parameter int V_IRQ  = 72
) (
  input logic       clk,
  input logic       rst,
  input logic       user_mode,
  input logic [7:0] pc_o,
  input logic [7:0] epc_o,
  input logic       mem_we,
  input logic [7:0] mem_addr,
  input logic       irq,
  input logic       irq_ack
);
  p_user_write_guard_r8: assert property (@(posedge clk) disable iff (rst)
    (user_mode && mem_we) |-> (mem_addr >= 8'(LIMIT)));

  p_ack_vector_r12: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (!user_mode && pc_o == 8'(V_IRQ) && $past(irq)));

  p_mode_drop_vectors_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(user_mode) |-> (pc_o == 8'(V_MEM) || pc_o == 8'(V_MODE) ||
                          pc_o == 8'(V_TRAP) || pc_o == 8'(V_IRQ)));

  p_epc_sys_only_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(epc_o) |-> !user_mode);

  p_ack_single_r12: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);
endmodule

bind m2m_core m2m_core_chk u_chk (
  .clk(clk), .rst(rst), .user_mode(user_mode), .pc_o(pc_o), .epc_o(epc_o),
  .mem_we(mem_we), .mem_addr(mem_addr), .irq(irq), .irq_ack(irq_ack)
);

// File: tb/m2m_core_tb.sv
module m2m_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {operation byte, first value, second value, expected destination}
  localparam logic [31:0] VECS [NVEC] = '{
    {8'd1, 8'd20,  8'd30,  8'd50},
    {8'd1, 8'd200, 8'd100, 8'd44},
    {8'd2, 8'd5,   8'd9,   8'd252},
    {8'd3, 8'd16,  8'd17,  8'd16},
    {8'd4, 8'd100, 8'd7,   8'd14},
    {8'd4, 8'd9,   8'd0,   8'd0},
    {8'd6, 8'd0,   8'd3,   8'd255}
  };

  logic clk = 1'b0, rst = 1'b1, irq = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, pc_o, epc_o, trap_num;
  logic mem_re, mem_we, irq_ack, user_mode;
  logic [7:0] mem [256];
  int total = 0, bad = 0, acks;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  m2m_core u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .irq_ack(irq_ack),
    .pc_o(pc_o), .epc_o(epc_o), .user_mode(user_mode), .trap_num(trap_num)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int a, input int o, input int s1, input int s2, input int d);
    mem[a] = 8'(o); mem[a+1] = 8'(s1); mem[a+2] = 8'(s2); mem[a+3] = 8'(d);
  endtask

  // Boot: 0 jumps to 96, service call at 96 drops to 68 which returns to 100 in user mode.
  task automatic setup();
    rst = 1'b1; irq = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    put(0, 7, 0, 0, 96);
    put(96, 8, 8'h11, 0, 0);
    put(60, 7, 0, 0, 60);
    put(64, 7, 0, 0, 64);
    put(68, 9, 0, 0, 0);
    put(72, 7, 0, 0, 72);
  endtask

  task automatic run(input int n);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ack();
    acks = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_ack) begin acks++; irq = 1'b0; end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    setup();
    repeat (3) @(negedge clk);
    chk("R1 pc", pc_o, 0);
    chk("R1 mode", user_mode, 0);
    chk("R1 we", mem_we, 0);
    chk("R1 ack", irq_ack, 0);

    // R2 R3 R5 vector table, user mode
    for (int v = 0; v < NVEC; v++) begin
      setup();
      put(100, VECS[v][31:24], 200, 201, 202);
      put(104, 7, 0, 0, 104);
      mem[200] = VECS[v][23:16]; mem[201] = VECS[v][15:8];
      run(150);
      chk("R2 R3 R5 result", mem[202], VECS[v][7:0]);
      chk("R2 pc", pc_o, 104);
    end

    // R4 indirect both sources
    setup();
    put(100, 8'hC1, 210, 211, 202); put(104, 7, 0, 0, 104);
    mem[210] = 200; mem[211] = 201; mem[200] = 7; mem[201] = 8;
    run(150);
    chk("R4 indirect", mem[202], 15);

    // R5 counted loop with branch-if-zero, decrement and jump
    setup();
    put(100, 5, 200, 0, 116); put(104, 1, 201, 203, 201);
    put(108, 6, 200, 0, 200); put(112, 7, 0, 0, 100); put(116, 7, 0, 0, 116);
    mem[200] = 3; mem[203] = 5;
    run(400);
    chk("R5 sum", mem[201], 15);
    chk("R5 exit pc", pc_o, 116);

    // R6 unknown opcode
    setup();
    put(100, 8'h0F, 200, 201, 202); put(104, 7, 0, 0, 104);
    mem[202] = 8'h33;
    run(150);
    chk("R6 pc", pc_o, 104);
    chk("R6 mode", user_mode, 1);
    chk("R6 mem", mem[202], 8'h33);

    // R7 user fetch from guarded region
    setup();
    put(100, 7, 0, 0, 40);
    run(150);
    chk("R7 pc", pc_o, 60);
    chk("R7 epc", epc_o, 40);
    chk("R7 mode", user_mode, 0);

    // R8 guarded source, destination, and pointer target
    setup();
    put(100, 1, 50, 201, 202); mem[202] = 8'h44;
    run(150);
    chk("R8 src pc", pc_o, 60);
    chk("R8 src epc", epc_o, 100);
    chk("R8 src mem", mem[202], 8'h44);
    setup();
    put(100, 1, 200, 201, 50); mem[50] = 8'h5A;
    run(150);
    chk("R8 dst pc", pc_o, 60);
    chk("R8 dst mem", mem[50], 8'h5A);
    setup();
    put(100, 8'h81, 210, 201, 202); mem[210] = 10;
    run(150);
    chk("R8 ptr pc", pc_o, 60);

    // R9 user writes privilege cell, user return
    setup();
    put(100, 1, 200, 201, 255); mem[200] = 1;
    run(150);
    chk("R9 cell pc", pc_o, 64);
    chk("R9 cell epc", epc_o, 100);
    setup();
    put(100, 9, 0, 0, 0);
    run(150);
    chk("R9 rte pc", pc_o, 64);
    chk("R9 rte mode", user_mode, 0);

    // R10 R11 service call from user then return
    setup();
    put(100, 8, 8'h33, 0, 0); put(104, 7, 0, 0, 104);
    run(200);
    chk("R10 num", trap_num, 8'h33);
    chk("R10 epc", epc_o, 104);
    chk("R11 pc", pc_o, 104);
    chk("R11 mode", user_mode, 1);

    // R13 system write of privilege cell
    setup();
    put(0, 1, 200, 201, 255); mem[200] = 1; mem[255] = 8'hAA;
    run(150);
    chk("R13 mem", mem[255], 8'hAA);
    chk("R13 pc", pc_o, 60);
    chk("R13 epc", epc_o, 4);

    // R12 interrupt in user loop
    setup();
    put(100, 7, 0, 0, 100);
    run(100);
    irq = 1'b1;
    wait_ack();
    chk("R12 pc", pc_o, 72);
    chk("R12 epc", epc_o, 100);
    chk("R12 mode", user_mode, 0);
    chk("R12 acks", acks, 1);

    // R12 interrupt and fetch guard in the same cycle
    setup();
    put(100, 7, 0, 0, 40);
    run(0);
    for (int i = 0; i < 200 && pc_o != 8'd40; i++) @(negedge clk);
    irq = 1'b1;
    wait_ack();
    chk("R12 prio pc", pc_o, 72);
    chk("R12 prio epc", epc_o, 40);
    chk("R12 prio acks", acks, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule